// File: doc/BRIEF.md
# Partial Reconfiguration Sequencer

This block is a hardware state machine that carries out a complete partial-reconfiguration exchange with a configuration target, so that no processor has to step through it. A single `start` pulse begins the run. The sequencer first checks the mode-select field and the two configuration pin levels on the status input. It then programs the bus width and the clock-to-data ratio. After that it switches on chip select, the configuration clock and data path, the reset-pin overrides and the stream overrides, one step at a time.

Between those steps it asks an external burst generator for fixed numbers of configuration clock pulses. It then polls for ready, forwards image words from an upstream source to the target, and polls for done. The setup is always undone before a result code is reported. A final status check separates a clean finish from a stalled one.

Image header parsing happens upstream. Two flags, `img_encrypted` and `img_compressed`, tell the sequencer how the image was prepared. Clock pulse generation is left to the burst generator.

Top module: `pr_seq_fsm`

## Requirements
- R1: On `start` while idle, if status bits [18:16] (mode select) are not 000 or 001, or status bit 12 (nCONFIG level) or bit 4 (nSTATUS level) is low, the block reports code 1 (invalid) in the next cycle. It stays idle, and no control output changes.
- R2: Setup drives `cfg_w32` to 0, selecting 16-bit width. It sets `cd_ratio` to 0 when the image is neither encrypted nor compressed, to 2 when it is compressed, and to 1 when it is encrypted only.
- R3: Setup runs in this order. Chip select goes low (`cs_n`=0) while `pin_ovr_n` is still 1. Then `cfg_en` rises. Then `rstovr_off` and `ncfg_hold` are both 1. Then `pin_ovr_n` falls. `pr_req` rises only after all of these.
- R4: Three bursts are requested in this order: 256 pulses after the stream overrides are on, 2047 pulses after `pr_req` rises, and 256 pulses after `pr_req` falls. `burst_req` and `burst_len` hold steady until `burst_done` is seen.
- R5: The ready wait (status bit 9) and the done wait (status bit 10) each sample status on at most 10 consecutive cycles. If the awaited bit does not appear in those samples, the result is code 2 (timeout).
- R6: Status bit 11 (error), seen on any polling cycle, ends that wait at once with code 3. It takes priority over ready or done seen in the same cycle.
- R7: Words pass from `din_*` to `tgt_*` with a valid/ready handshake, and only between ready and the accepted word marked `din_last`. At all other times `tgt_valid` and `din_ready` are 0.
- R8: A word with `din_nbytes`=1, 2 or 3 reaches the target with every byte above the lowest 1, 2 or 3 bytes forced to zero. A word with `din_nbytes`=0 is passed unchanged.
- R9: Teardown runs after every run that passed the pin check, including runs whose ready or done wait failed. It clears `pr_req`, then requests the closing burst, then clears `cfg_en`, then raises `cs_n`, then raises `pin_ovr_n`.
- R10: After teardown of a run whose waits succeeded, the result is code 0 only if status bits 2 (user mode), 6 (CONF_DONE) and 4 (nSTATUS) are all high. Otherwise it is code 2.
- R11: Each run yields exactly one `res_valid` pulse, one cycle long, and `busy` is 0 in that cycle. Codes are 0 ok, 1 invalid, 2 timeout and 3 error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled when idle) |
| img_encrypted | input | 1 | Image is encrypted |
| img_compressed | input | 1 | Image is compressed |
| status | input | 32 | Target status word |
| burst_req | output | 1 | Burst request to the pulse generator |
| burst_len | output | 12 | Pulse count of the requested burst |
| burst_done | input | 1 | Burst generator finished |
| din_valid | input | 1 | Upstream word valid |
| din_ready | output | 1 | Upstream word accepted |
| din_data | input | 32 | Upstream image word |
| din_nbytes | input | 2 | Valid byte count, 0 = all four |
| din_last | input | 1 | Final word of the image |
| tgt_valid | output | 1 | Word valid toward target |
| tgt_ready | input | 1 | Target accepts word |
| tgt_data | output | 32 | Masked word toward target |
| cfg_w32 | output | 1 | Width field, 1 = 32-bit, 0 = 16-bit |
| cd_ratio | output | 2 | Clock-to-data ratio field |
| cfg_en | output | 1 | Configuration clock and data enable |
| cs_n | output | 1 | Chip select, active low |
| rstovr_off | output | 1 | Reset-pin overrides released |
| ncfg_hold | output | 1 | nCONFIG drive level |
| pin_ovr_n | output | 1 | Stream overrides, 0 = enabled |
| pr_req | output | 1 | Partial reconfiguration request |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | Result strobe |
| res_code | output | 2 | Result code |

## Verification
The assertions assume that `burst_done` arrives only while `burst_req` is high. They also assume that upstream words stay stable while `din_valid` waits for `din_ready`, and that status changes are synchronous to the clock. The bench's burst responder raises `burst_done` only after it has seen a request, and holds it for a single cycle. Its word driver changes data only after a transfer has completed. All status and input changes are driven on the falling edge, so every polling sample sees settled values.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int WORD_W   = 32;
    localparam int STAT_W   = 32;
    localparam int BLEN_W   = 12;

    localparam int B_UMODE  = 2;
    localparam int B_NSTAT  = 4;
    localparam int B_CDONE  = 6;
    localparam int B_RDY    = 9;
    localparam int B_DONE   = 10;
    localparam int B_ERR    = 11;
    localparam int B_NCFG   = 12;
    localparam int B_MSEL   = 16;
    localparam int MSEL_W   = 3;

    localparam logic [BLEN_W-1:0] LEN_FLUSH = BLEN_W'(256);
    localparam logic [BLEN_W-1:0] LEN_PRE   = BLEN_W'(2047);

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_INVALID = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_ERROR   = 2'd3
    } res_e;

    typedef enum logic [4:0] {
        S_IDLE, S_FMT, S_CS, S_CFGEN, S_RSTOVR, S_OVRON, S_B_FLUSH1,
        S_REQ, S_B_PRE, S_WRDY, S_STREAM, S_WDONE, S_REQOFF,
        S_B_FLUSH2, S_CFGOFF, S_CSOFF, S_OVROFF, S_FINAL, S_REPORT
    } st_e;

    function automatic logic [1:0] ratio_code(input logic w32,
                                              input logic enc,
                                              input logic cmp);
        logic [1:0] r;
        if (!enc && !cmp) return 2'd0;
        r = cmp ? 2'd2 : 2'd1;
        if (w32) r = r + 2'd1;
        return r;
    endfunction

    function automatic logic mode_ok(input logic [MSEL_W-1:0] m);
        return (m == 3'd0) || (m == 3'd1);
    endfunction

endpackage

// File: rtl/prs_poller.sv
module prs_poller #(
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic hit,
    input  logic err,
    output logic pass,
    output logic fail_err,
    output logic fail_to
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt;

    assign fail_err = active && err;
    assign pass     = active && !err && hit;
    assign fail_to  = active && !err && !hit && (cnt == CW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (!pass && !fail_err && !fail_to) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/prs_word_mask.sv
module prs_word_mask #(
    parameter int W = 32
) (
    input  logic [W-1:0]               din,
    input  logic [$clog2(W/8)-1:0]     nbytes,
    output logic [W-1:0]               dout
);
    localparam int LANES = W / 8;
    localparam int NB_W  = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic keep;
        assign keep = (nbytes == '0) || (NB_W'(g) < nbytes);
        assign dout[g*8 +: 8] = keep ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pr_seq_fsm.sv
module pr_seq_fsm
    import prs_pkg::*;
#(
    parameter int W         = WORD_W,
    parameter int SW        = STAT_W,
    parameter int MAX_POLLS = 10,
    parameter int NB_W      = $clog2(W/8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              img_encrypted,
    input  logic              img_compressed,
    input  logic [SW-1:0]     status,
    output logic              burst_req,
    output logic [BLEN_W-1:0] burst_len,
    input  logic              burst_done,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [W-1:0]      din_data,
    input  logic [NB_W-1:0]   din_nbytes,
    input  logic              din_last,
    output logic              tgt_valid,
    input  logic              tgt_ready,
    output logic [W-1:0]      tgt_data,
    output logic              cfg_w32,
    output logic [1:0]        cd_ratio,
    output logic              cfg_en,
    output logic              cs_n,
    output logic              rstovr_off,
    output logic              ncfg_hold,
    output logic              pin_ovr_n,
    output logic              pr_req,
    output logic              busy,
    output logic              res_valid,
    output logic [1:0]        res_code
);
    st_e  st;
    res_e res_q;

    logic pins_ok;
    logic poll_active, poll_hit, poll_pass, poll_err, poll_to;
    logic xfer;
    logic unused_status;

    assign unused_status = ^status;

    assign pins_ok = mode_ok(status[B_MSEL +: MSEL_W]) &&
                     status[B_NCFG] && status[B_NSTAT];

    assign poll_active = (st == S_WRDY) || (st == S_WDONE);
    assign poll_hit    = (st == S_WRDY) ? status[B_RDY] : status[B_DONE];

    prs_poller #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .active   (poll_active),
        .hit      (poll_hit),
        .err      (status[B_ERR]),
        .pass     (poll_pass),
        .fail_err (poll_err),
        .fail_to  (poll_to)
    );

    prs_word_mask #(.W(W)) u_mask (
        .din    (din_data),
        .nbytes (din_nbytes),
        .dout   (tgt_data)
    );

    assign tgt_valid = (st == S_STREAM) && din_valid;
    assign din_ready = (st == S_STREAM) && tgt_ready;
    assign xfer      = tgt_valid && tgt_ready;

    always_comb begin
        burst_req = 1'b0;
        burst_len = LEN_FLUSH;
        case (st)
            S_B_FLUSH1, S_B_FLUSH2: burst_req = 1'b1;
            S_B_PRE: begin
                burst_req = 1'b1;
                burst_len = LEN_PRE;
            end
            default: ;
        endcase
    end

    assign busy = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            res_q      <= RES_OK;
            res_valid  <= 1'b0;
            res_code   <= 2'd0;
            cfg_w32    <= 1'b1;
            cd_ratio   <= 2'd0;
            cfg_en     <= 1'b0;
            cs_n       <= 1'b1;
            rstovr_off <= 1'b0;
            ncfg_hold  <= 1'b1;
            pin_ovr_n  <= 1'b1;
            pr_req     <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        if (pins_ok) begin
                            res_q <= RES_OK;
                            st    <= S_FMT;
                        end else begin
                            res_code  <= RES_INVALID;
                            res_valid <= 1'b1;
                        end
                    end
                end
                S_FMT: begin
                    cfg_w32  <= 1'b0;
                    cd_ratio <= ratio_code(1'b0, img_encrypted, img_compressed);
                    st       <= S_CS;
                end
                S_CS: begin
                    cs_n <= 1'b0;
                    st   <= S_CFGEN;
                end
                S_CFGEN: begin
                    cfg_en <= 1'b1;
                    st     <= S_RSTOVR;
                end
                S_RSTOVR: begin
                    rstovr_off <= 1'b1;
                    ncfg_hold  <= 1'b1;
                    st         <= S_OVRON;
                end
                S_OVRON: begin
                    pin_ovr_n <= 1'b0;
                    st        <= S_B_FLUSH1;
                end
                S_B_FLUSH1: if (burst_done) st <= S_REQ;
                S_REQ: begin
                    pr_req <= 1'b1;
                    st     <= S_B_PRE;
                end
                S_B_PRE: if (burst_done) st <= S_WRDY;
                S_WRDY: begin
                    if (poll_err) begin
                        res_q <= RES_ERROR;
                        st    <= S_REQOFF;
                    end else if (poll_pass) begin
                        st <= S_STREAM;
                    end else if (poll_to) begin
                        res_q <= RES_TIMEOUT;
                        st    <= S_REQOFF;
                    end
                end
                S_STREAM: if (xfer && din_last) st <= S_WDONE;
                S_WDONE: begin
                    if (poll_err) begin
                        res_q <= RES_ERROR;
                        st    <= S_REQOFF;
                    end else if (poll_pass) begin
                        st <= S_REQOFF;
                    end else if (poll_to) begin
                        res_q <= RES_TIMEOUT;
                        st    <= S_REQOFF;
                    end
                end
                S_REQOFF: begin
                    pr_req <= 1'b0;
                    st     <= S_B_FLUSH2;
                end
                S_B_FLUSH2: if (burst_done) st <= S_CFGOFF;
                S_CFGOFF: begin
                    cfg_en <= 1'b0;
                    st     <= S_CSOFF;
                end
                S_CSOFF: begin
                    cs_n <= 1'b1;
                    st   <= S_OVROFF;
                end
                S_OVROFF: begin
                    pin_ovr_n <= 1'b1;
                    st        <= (res_q == RES_OK) ? S_FINAL : S_REPORT;
                end
                S_FINAL: begin
                    res_code  <= (status[B_UMODE] && status[B_CDONE] &&
                                  status[B_NSTAT]) ? RES_OK : RES_TIMEOUT;
                    res_valid <= 1'b1;
                    st        <= S_IDLE;
                end
                S_REPORT: begin
                    res_code  <= res_q;
                    res_valid <= 1'b1;
                    st        <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prs_checker.sv
module prs_checker
    import prs_pkg::*;
#(
    parameter int W    = 32,
    parameter int SW   = 32,
    parameter int NB_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [SW-1:0]     status,
    input logic              burst_req,
    input logic [BLEN_W-1:0] burst_len,
    input logic              burst_done,
    input logic              din_valid,
    input logic [NB_W-1:0]   din_nbytes,
    input logic              tgt_valid,
    input logic [W-1:0]      tgt_data,
    input logic              cfg_en,
    input logic              cs_n,
    input logic              rstovr_off,
    input logic              ncfg_hold,
    input logic              pin_ovr_n,
    input logic              pr_req,
    input logic              busy,
    input logic              res_valid,
    input logic [1:0]        res_code
);
    AST_BAD_START_INVALID: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !(mode_ok(status[B_MSEL +: MSEL_W]) && status[B_NCFG] && status[B_NSTAT]))
        |=> (res_valid && res_code == RES_INVALID && !busy)); // R1

    AST_OVR_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_ovr_n) |-> (!cs_n && cfg_en && rstovr_off && ncfg_hold)); // R3

    AST_REQ_IN_CONTEXT: assert property (@(posedge clk) disable iff (rst)
        pr_req |-> (!pin_ovr_n && !cs_n && cfg_en)); // R3

    AST_BURST_HELD: assert property (@(posedge clk) disable iff (rst)
        (burst_req && !burst_done) |=> (burst_req && $stable(burst_len))); // R4

    AST_STREAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> (pr_req && din_valid)); // R7

    AST_MASK_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && din_nbytes == NB_W'(1)) |-> (tgt_data[W-1:8] == '0)); // R8

    AST_TORN_DOWN: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (cs_n && pin_ovr_n && !pr_req && !cfg_en)); // R9

    AST_OK_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_code == RES_OK) |->
        $past(status[B_UMODE] && status[B_CDONE] && status[B_NSTAT])); // R10

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R11
endmodule

bind pr_seq_fsm prs_checker #(.W(W), .SW(SW), .NB_W(NB_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .status(status),
    .burst_req(burst_req), .burst_len(burst_len), .burst_done(burst_done),
    .din_valid(din_valid), .din_nbytes(din_nbytes), .tgt_valid(tgt_valid),
    .tgt_data(tgt_data), .cfg_en(cfg_en), .cs_n(cs_n),
    .rstovr_off(rstovr_off), .ncfg_hold(ncfg_hold), .pin_ovr_n(pin_ovr_n),
    .pr_req(pr_req), .busy(busy), .res_valid(res_valid), .res_code(res_code)
);

// File: tb/tb_pr_seq_fsm.sv
module tb_pr_seq_fsm;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        img_encrypted = 1'b0;
    logic        img_compressed = 1'b0;
    logic [31:0] status;
    logic        burst_req;
    logic [11:0] burst_len;
    logic        burst_done = 1'b0;
    logic        din_valid = 1'b0;
    logic        din_ready;
    logic [31:0] din_data = '0;
    logic [1:0]  din_nbytes = '0;
    logic        din_last = 1'b0;
    logic        tgt_valid;
    logic        tgt_ready = 1'b1;
    logic [31:0] tgt_data;
    logic        cfg_w32;
    logic [1:0]  cd_ratio;
    logic        cfg_en, cs_n, rstovr_off, ncfg_hold, pin_ovr_n, pr_req;
    logic        busy, res_valid;
    logic [1:0]  res_code;

    logic [2:0] msel = 3'd1;
    logic ncfg_b = 1'b1, nst_b = 1'b1, rdy_b = 1'b0, done_b = 1'b0;
    logic err_b = 1'b0, um_b = 1'b1, cdone_b = 1'b1;
    int   rdy_act = 1;
    int   rdy_delay = 3;

    always_comb begin
        status = '0;
        status[18:16] = msel;
        status[12] = ncfg_b;
        status[11] = err_b;
        status[10] = done_b;
        status[9]  = rdy_b;
        status[6]  = cdone_b;
        status[4]  = nst_b;
        status[2]  = um_b;
    end

    always #(CLK_PERIOD/2) clk = ~clk;

    pr_seq_fsm dut (
        .clk(clk), .rst(rst), .start(start), .img_encrypted(img_encrypted),
        .img_compressed(img_compressed), .status(status),
        .burst_req(burst_req), .burst_len(burst_len), .burst_done(burst_done),
        .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
        .din_nbytes(din_nbytes), .din_last(din_last), .tgt_valid(tgt_valid),
        .tgt_ready(tgt_ready), .tgt_data(tgt_data), .cfg_w32(cfg_w32),
        .cd_ratio(cd_ratio), .cfg_en(cfg_en), .cs_n(cs_n),
        .rstovr_off(rstovr_off), .ncfg_hold(ncfg_hold), .pin_ovr_n(pin_ovr_n),
        .pr_req(pr_req), .busy(busy), .res_valid(res_valid), .res_code(res_code)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct { logic [1:0] code; string req; } exp_t;
    exp_t        res_exp[$];
    logic [31:0] data_exp[$];
    int          blog[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // result scoreboard monitor
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (res_exp.size() == 0) begin
                chk(0, "R11", "unexpected result", res_code, 0);
            end else begin
                exp_t e;
                e = res_exp.pop_front();
                chk(res_code == e.code, e.req, "result code", res_code, e.code);
                chk(!busy, "R11", "busy with result", busy, 0);
            end
        end
    end

    // data scoreboard monitor
    always @(negedge clk) begin
        if (!rst && tgt_valid && tgt_ready) begin
            if (data_exp.size() == 0) begin
                chk(0, "R7", "unexpected word", tgt_data, 0);
            end else begin
                logic [31:0] e;
                e = data_exp.pop_front();
                chk(tgt_data == e, "R8", "target word", tgt_data, e);
            end
        end
    end

    // ordering monitor
    logic p_cs_n = 1, p_ovr_n = 1, p_req = 0, p_cfg_en = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (p_cs_n && !cs_n)
                chk(pin_ovr_n && !cfg_en && !cfg_w32, "R3", "chip select step", {pin_ovr_n, cfg_en, cfg_w32}, 3'b100);
            if (p_ovr_n && !pin_ovr_n)
                chk(cfg_en && rstovr_off && ncfg_hold && !cs_n, "R3", "override step", {cfg_en, rstovr_off, ncfg_hold, cs_n}, 4'b1110);
            if (!p_req && pr_req)
                chk(!pin_ovr_n && !cs_n && cfg_en && blog.size() == 1, "R4", "request step", blog.size(), 1);
            if (p_cfg_en && !cfg_en)
                chk(!pr_req && !cs_n && !pin_ovr_n, "R9", "clock off step", {pr_req, cs_n, pin_ovr_n}, 3'b000);
            if (!p_ovr_n && pin_ovr_n)
                chk(cs_n && !cfg_en, "R9", "override off step", {cs_n, cfg_en}, 2'b10);
        end
        p_cs_n = cs_n; p_ovr_n = pin_ovr_n; p_req = pr_req; p_cfg_en = cfg_en;
    end

    // burst generator model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && burst_req) begin
                int l;
                l = int'(burst_len);
                repeat (2) @(negedge clk);
                burst_done = 1'b1;
                @(posedge clk);
                @(negedge clk);
                burst_done = 1'b0;
                blog.push_back(l);
                if (l == 2047 && rdy_act != 0) begin
                    repeat (rdy_delay) @(posedge clk);
                    @(negedge clk);
                    if (rdy_act == 1) rdy_b = 1'b1;
                    else err_b = 1'b1;
                end
            end
        end
    end

    task automatic send_word(input logic [31:0] d, input logic [1:0] nb, input bit last);
        logic [31:0] m;
        m = (nb == 2'd0) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 32'h1);
        data_exp.push_back(d & m);
        din_data = d; din_nbytes = nb; din_last = last; din_valid = 1'b1;
        while (!din_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        din_valid = 1'b0; din_last = 1'b0;
    endtask

    // done_mode: 0 done bit set, 1 error after stream, 2 done never seen
    task automatic run(input bit enc, input bit cmp, input bit do_stream,
                       input int nwords, input logic [1:0] last_nb,
                       input int ract, input int rdel, input int done_mode,
                       input logic um, input logic [1:0] code, input string req,
                       input logic [1:0] exp_ratio);
        @(negedge clk);
        rdy_b = 0; err_b = 0; done_b = (done_mode == 0); um_b = um;
        rdy_act = ract; rdy_delay = rdel;
        img_encrypted = enc; img_compressed = cmp;
        res_exp.push_back('{code, req});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (do_stream) begin
            for (int i = 0; i < nwords; i++) begin
                send_word(32'hC3A5_9611 ^ (i * 32'h1111_1111),
                          (i == nwords - 1) ? last_nb : 2'd0, i == nwords - 1);
            end
            if (done_mode == 1) err_b = 1'b1;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(res_exp.size() == 0, "R11", "result delivered", res_exp.size(), 0);
        chk(cs_n && pin_ovr_n && !pr_req && !cfg_en, "R9", "torn down",
            {cs_n, pin_ovr_n, pr_req, cfg_en}, 4'b1100);
        chk(blog.size() == 3, "R4", "burst count", blog.size(), 3);
        if (blog.size() == 3) begin
            chk(blog[0] == 256, "R4", "first burst", blog[0], 256);
            chk(blog[1] == 2047, "R4", "second burst", blog[1], 2047);
            chk(blog[2] == 256, "R9", "closing burst", blog[2], 256);
        end
        chk(!cfg_w32 && cd_ratio == exp_ratio, "R2", "width/ratio",
            {cfg_w32, cd_ratio}, {1'b0, exp_ratio});
        chk(data_exp.size() == 0, "R7", "words delivered", data_exp.size(), 0);
        blog.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic run_bad(input logic [2:0] m, input logic nc, input logic ns);
        @(negedge clk);
        msel = m; ncfg_b = nc; nst_b = ns;
        res_exp.push_back('{2'd1, "R1"});
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && cs_n && pin_ovr_n && !pr_req && !burst_req, "R1", "no action",
            {busy, cs_n, pin_ovr_n, pr_req, burst_req}, 5'b01100);
        @(negedge clk);
        chk(res_exp.size() == 0, "R1", "invalid reported", res_exp.size(), 0);
        msel = 3'd1; ncfg_b = 1; nst_b = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
        wrap_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && pin_ovr_n && !pr_req && !cfg_en && !busy && !res_valid,
            "R11", "reset state", {cs_n, pin_ovr_n, pr_req, cfg_en, busy, res_valid}, 6'b110000);
        // words offered while idle are ignored
        din_valid = 1'b1; din_data = 32'hDEAD_BEEF;
        @(negedge clk);
        chk(!tgt_valid && !din_ready, "R7", "idle stream blocked", {tgt_valid, din_ready}, 0);
        din_valid = 1'b0;

        run_bad(3'd2, 1'b1, 1'b1);
        run_bad(3'd0, 1'b1, 1'b0);
        run_bad(3'd1, 1'b0, 1'b1);

        // nominal, compressed, partial last word of 2 bytes
        run(1'b0, 1'b1, 1'b1, 3, 2'd2, 1, 3, 0, 1'b1, 2'd0, "R10", 2'd2);
        // encrypted only, last word of 1 byte
        run(1'b1, 1'b0, 1'b1, 2, 2'd1, 1, 5, 0, 1'b1, 2'd0, "R10", 2'd1);
        // plain image, last word of 3 bytes, ready on the tenth sample
        run(1'b0, 1'b0, 1'b1, 4, 2'd3, 1, 9, 0, 1'b1, 2'd0, "R5", 2'd0);
        // ready one sample too late
        run(1'b0, 1'b0, 1'b0, 0, 2'd0, 1, 10, 0, 1'b1, 2'd2, "R5", 2'd0);
        // ready never arrives
        run(1'b0, 1'b1, 1'b0, 0, 2'd0, 0, 0, 0, 1'b1, 2'd2, "R5", 2'd2);
        // error during ready wait, with done bit also high
        run(1'b1, 1'b1, 1'b0, 0, 2'd0, 2, 2, 0, 1'b1, 2'd3, "R6", 2'd2);
        // error during done wait
        run(1'b0, 1'b0, 1'b1, 2, 2'd0, 1, 1, 1, 1'b1, 2'd3, "R6", 2'd0);
        // done never arrives
        run(1'b0, 1'b0, 1'b1, 1, 2'd0, 1, 1, 2, 1'b1, 2'd2, "R5", 2'd0);
        // final check sees user mode low
        run(1'b0, 1'b0, 1'b1, 1, 2'd0, 1, 1, 0, 1'b0, 2'd2, "R10", 2'd0);

        wrap_up();
    end
endmodule